// File: doc/BRIEF.md
# Two-Slot Accumulator Processor Sequencer

This block is a small stored-program processor built around a single accumulator. It has an internal word-addressed memory of 40-bit words. Each word carries two 20-bit instructions. A cycle-level state machine steps through fetch, decode, operand access, execute and an interrupt-check phase. The left instruction of a word runs first. The right half waits in an instruction buffer and issues without a second memory read. The program counter moves on only once that right half has issued.

A single interrupt request is sampled in the check phase that closes every instruction. When the request is taken, the program counter, the accumulator and any buffered right-hand instruction are copied into shadow registers. Control then goes to a fixed handler address, and further requests are masked until a return instruction restores the saved context.

Memory is filled through a load port while the `run` input is low. Holding `run` low freezes the processor. The main registers are brought out as observation taps.

Top module: `acc_core`

## Requirements
- R1: After reset, PC and ACC read zero, and `irq_ack`, `in_handler`, `mem_rd` and `mem_wr` are all low.
- R2: An instruction is 20 bits: opcode in bits 19:12 and address in bits 11:0. A word holds the first instruction in bits 39:20 and the second in bits 19:0. The second runs from the buffer with no extra memory read.
- R3: PC advances by one when a second-slot instruction is decoded, and stays put in every other phase except a taken jump or interrupt entry. From DEPTH-1 it wraps to 0.
- R4: `mem_rd` and `mem_wr` are separate strobes and are never both high. STORE (0x21) holds `mem_wr` for one cycle, writing ACC to the instruction's address.
- R5: LOAD (0x01) sets ACC to the memory word. ADD (0x05) and SUB (0x06) add or subtract it modulo 2^40. Any other undefined opcode does nothing.
- R6: JUMP (0x0D) always loads PC with the address. JUMP-if-non-negative (0x0F) does so only when ACC bit 39 is 0. A taken jump discards a buffered second-slot instruction.
- R7: After each instruction, if `irq` is high and not masked, `irq_ack` is high for exactly one cycle. PC, ACC and the buffered half are saved, PC becomes HANDLER_ADDR, and `in_handler` rises.
- R8: While `in_handler` is high, no request is acknowledged. Return (0x3F) restores the saved PC, ACC and buffered half, and clears `in_handler`.
- R9: The phase counts per instruction are fixed. A first-slot fetch takes 3 cycles and a second-slot fetch takes 1. Decode takes 1. LOAD, ADD and SUB take 2 more cycles, and STORE takes 1. Every instruction ends with 1 interrupt-check cycle.
- R10: While `run` is low, all processor state holds and the load port writes memory. While `run` is high, the load port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High lets the sequencer advance; low freezes it and enables loading |
| irq | input | 1 | Interrupt request, level sensitive |
| ld_en | input | 1 | Load-port write strobe (effective while run is low) |
| ld_addr | input | ADDR_W | Load-port word address |
| ld_data | input | 2*(8+ADDR_W) | Load-port word data |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |
| in_handler | output | 1 | High while interrupts are masked (inside the handler) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dbg_pc | output | ADDR_W | Program counter tap |
| dbg_mar | output | ADDR_W | Memory address register tap |
| dbg_mbr | output | 2*(8+ADDR_W) | Memory buffer register tap |
| dbg_ir | output | 8+ADDR_W | Instruction register tap |
| dbg_ibr | output | 8+ADDR_W | Instruction buffer register tap |
| dbg_acc | output | 2*(8+ADDR_W) | Accumulator tap |

## Verification
The bench counts clock edges from the cycle `run` rises. With the first program, the first STORE's write strobe is due in the sixteenth cycle. With the interrupt program, the acknowledge is due in the sixth cycle, because the first LOAD takes seven phases. Both cycle counts are sampled on the falling edge. Memory writes can land at many points in a run, so they go to a scoreboard. Expected (address, data) pairs are queued before the run. Each write strobe pops one pair and compares it against MAR and MBR. A write that finds the queue empty is a failure. This catches discarded second-slot STOREs that still execute.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OP_W-1:0] OP_ADD   = 8'h05;
  localparam logic [OP_W-1:0] OP_SUB   = 8'h06;
  localparam logic [OP_W-1:0] OP_STORE = 8'h21;
  localparam logic [OP_W-1:0] OP_JUMP  = 8'h0D;
  localparam logic [OP_W-1:0] OP_JGE   = 8'h0F;
  localparam logic [OP_W-1:0] OP_RETI  = 8'h3F;

  typedef enum logic [2:0] {
    ST_FETCH, ST_READ, ST_SPLIT, ST_DECODE,
    ST_OPRD, ST_ALU, ST_WRITE, ST_INTCHK
  } state_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_op_e;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int W      = 40,
  parameter int AW     = 12,
  parameter int DEPTH  = 1000,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0]  cells [DEPTH];
  logic [IW-1:0] widx, ridx;

  assign widx = waddr[IW-1:0];
  assign ridx = raddr[IW-1:0];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) cells[widx] <= wdata;
  end

  assign rdata = (int'(raddr) < DEPTH) ? cells[ridx] : '0;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 40
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ibr_valid,
  input  logic [OP_W-1:0] opcode,
  output state_e          state
);
  state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_FETCH:  state_d = ibr_valid ? ST_DECODE : ST_READ;
      ST_READ:   state_d = ST_SPLIT;
      ST_SPLIT:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB: state_d = ST_OPRD;
          OP_STORE:                state_d = ST_WRITE;
          default:                 state_d = ST_INTCHK;
        endcase
      end
      ST_OPRD:   state_d = ST_ALU;
      ST_ALU:    state_d = ST_INTCHK;
      ST_WRITE:  state_d = ST_INTCHK;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= ST_FETCH;
    else if (run) state <= state_d;
  end

  a_r9_read_then_split: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == ST_READ) |=> (state == ST_SPLIT));
  a_r9_check_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == ST_INTCHK) |=> (state == ST_FETCH));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter int                DEPTH        = 1000,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'd768,
  localparam int               IW           = OP_W + ADDR_W,
  localparam int               WW           = 2 * IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              irq,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WW-1:0]     ld_data,
  output logic              irq_ack,
  output logic              in_handler,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [WW-1:0]     dbg_mbr,
  output logic [IW-1:0]     dbg_ir,
  output logic [IW-1:0]     dbg_ibr,
  output logic [WW-1:0]     dbg_acc
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_c_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_c_n = rsync[1];

  state_e            state;
  logic [ADDR_W-1:0] pc, pc_d, mar, mar_d, sv_pc, sv_pc_d;
  logic [WW-1:0]     mbr, mbr_d, acc, acc_d, sv_acc, sv_acc_d;
  logic [IW-1:0]     ir, ir_d, ibr, ibr_d, sv_ibr, sv_ibr_d;
  logic              ibr_v, ibr_v_d, sv_ibr_v, sv_ibr_v_d;
  logic              right, right_d, masked, masked_d;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] opnd, pc_inc;
  logic [WW-1:0]     rdata, alu_y;
  alu_op_e           alu_sel;
  logic              take_irq;

  assign op     = ir[IW-1:ADDR_W];
  assign opnd   = ir[ADDR_W-1:0];
  assign pc_inc = (pc == LAST) ? '0 : pc + 1'b1;

  acc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_c_n), .run(run), .ibr_valid(ibr_v),
    .opcode(op), .state(state)
  );

  acc_mem #(.W(WW), .AW(ADDR_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk),
    .we(run ? (state == ST_WRITE) : ld_en),
    .waddr(run ? mar : ld_addr),
    .wdata(run ? mbr : ld_data),
    .raddr(mar),
    .rdata(rdata)
  );

  always_comb begin
    case (op)
      OP_ADD:  alu_sel = ALU_ADD;
      OP_SUB:  alu_sel = ALU_SUB;
      default: alu_sel = ALU_PASS;
    endcase
  end

  acc_alu #(.W(WW)) u_alu (.op(alu_sel), .a(acc), .b(mbr), .y(alu_y));

  assign take_irq = (state == ST_INTCHK) && irq && !masked;

  always_comb begin
    pc_d = pc;   mar_d = mar;   mbr_d = mbr;   acc_d = acc;
    ir_d = ir;   ibr_d = ibr;   ibr_v_d = ibr_v;
    right_d = right;  masked_d = masked;
    sv_pc_d = sv_pc;  sv_acc_d = sv_acc;
    sv_ibr_d = sv_ibr;  sv_ibr_v_d = sv_ibr_v;
    case (state)
      ST_FETCH: begin
        if (ibr_v) begin
          ir_d = ibr;  ibr_v_d = 1'b0;  right_d = 1'b1;
        end else begin
          mar_d = pc;
        end
      end
      ST_READ:  mbr_d = rdata;
      ST_SPLIT: begin
        ir_d = mbr[WW-1:IW];  ibr_d = mbr[IW-1:0];
        ibr_v_d = 1'b1;       right_d = 1'b0;
      end
      ST_DECODE: begin
        mar_d = opnd;
        if (right) pc_d = pc_inc;
        case (op)
          OP_STORE: mbr_d = acc;
          OP_JUMP: begin
            pc_d = opnd;  ibr_v_d = 1'b0;
          end
          OP_JGE: begin
            if (!acc[WW-1]) begin
              pc_d = opnd;  ibr_v_d = 1'b0;
            end
          end
          OP_RETI: begin
            pc_d = sv_pc;  acc_d = sv_acc;
            ibr_d = sv_ibr;  ibr_v_d = sv_ibr_v;  masked_d = 1'b0;
          end
          default: ;
        endcase
      end
      ST_OPRD: mbr_d = rdata;
      ST_ALU:  acc_d = alu_y;
      ST_INTCHK: begin
        if (take_irq) begin
          sv_pc_d = pc;  sv_acc_d = acc;  sv_ibr_d = ibr;  sv_ibr_v_d = ibr_v;
          pc_d = HANDLER_ADDR;  ibr_v_d = 1'b0;  masked_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_c_n) begin
    if (!rst_c_n) begin
      pc <= '0;  mar <= '0;  mbr <= '0;  acc <= '0;
      ir <= '0;  ibr <= '0;  ibr_v <= 1'b0;  right <= 1'b0;  masked <= 1'b0;
      sv_pc <= '0;  sv_acc <= '0;  sv_ibr <= '0;  sv_ibr_v <= 1'b0;
    end else if (run) begin
      pc <= pc_d;  mar <= mar_d;  mbr <= mbr_d;  acc <= acc_d;
      ir <= ir_d;  ibr <= ibr_d;  ibr_v <= ibr_v_d;  right <= right_d;
      masked <= masked_d;
      sv_pc <= sv_pc_d;  sv_acc <= sv_acc_d;
      sv_ibr <= sv_ibr_d;  sv_ibr_v <= sv_ibr_v_d;
    end
  end

  assign irq_ack    = run && take_irq;
  assign in_handler = masked;
  assign mem_rd     = run && ((state == ST_READ) || (state == ST_OPRD));
  assign mem_wr     = run && (state == ST_WRITE);
  assign dbg_pc  = pc;   assign dbg_mar = mar;  assign dbg_mbr = mbr;
  assign dbg_ir  = ir;   assign dbg_ibr = ibr;  assign dbg_acc = acc;

  a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_c_n)
    !(mem_rd && mem_wr));
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_c_n)
    irq_ack |=> !irq_ack);
  a_r7_ack_vectors: assert property (@(posedge clk) disable iff (!rst_c_n)
    irq_ack |=> (pc == HANDLER_ADDR) && in_handler);
  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_c_n)
    (in_handler && !(state == ST_DECODE && op == OP_RETI)) |=> in_handler);
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_c_n)
    (run && state != ST_DECODE && state != ST_INTCHK) |=> $stable(pc));
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_c_n)
    !run |=> ($stable(pc) && $stable(acc) && $stable(in_handler)));
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
  import acc_pkg::*;
  localparam int AW = 12;
  localparam int WW = 40;

  logic          clk = 1'b0;
  logic          rst_n, run, irq, ld_en;
  logic [AW-1:0] ld_addr;
  logic [WW-1:0] ld_data;
  logic          irq_ack, in_handler, mem_rd, mem_wr;
  logic [AW-1:0] dbg_pc, dbg_mar;
  logic [WW-1:0] dbg_mbr, dbg_acc;
  logic [19:0]   dbg_ir, dbg_ibr;

  always #4 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .irq(irq),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .irq_ack(irq_ack), .in_handler(in_handler), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .dbg_pc(dbg_pc), .dbg_mar(dbg_mar), .dbg_mbr(dbg_mbr),
    .dbg_ir(dbg_ir), .dbg_ibr(dbg_ibr), .dbg_acc(dbg_acc)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_rd = 0, n_wr = 0, n_ack = 0;
  int first_wr = -1, first_ack = -1, rd_before_wr = -1;
  bit strict = 1'b0, seen301 = 1'b0, done = 1'b0;
  logic [AW+WW-1:0] exp_q[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] ins(logic [7:0] o, logic [11:0] a);
    return {o, a};
  endfunction

  task automatic poke(int a, logic [WW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_wr(int a, logic [WW-1:0] d);
    exp_q.push_back({AW'(a), d});
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0; irq = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc = 0; n_rd = 0; n_wr = 0; n_ack = 0;
    first_wr = -1; first_ack = -1; rd_before_wr = -1; seen301 = 1'b0;
  endtask

  always @(posedge clk) if (run && rst_n) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_rd) n_rd++;
      if (irq_ack) begin
        n_ack++;
        if (first_ack < 0) first_ack = cyc;
      end
      if (mem_wr) begin
        n_wr++;
        if (first_wr < 0) begin first_wr = cyc; rd_before_wr = n_rd; end
        if (dbg_mar == 12'd301) seen301 = 1'b1;
        if (exp_q.size() > 0) begin
          logic [AW+WW-1:0] item;
          item = exp_q.pop_front();
          chk("R4/R5 store pair (addr,data)", {dbg_mar, dbg_mbr}, item);
        end else if (strict) begin
          n_chk++; n_fail++;
          $display("FAIL R6 unexpected write actual=%0h:%0h expected=none",
                   dbg_mar, dbg_mbr);
        end
      end
    end
  end

  task automatic drain(int lim);
    for (int i = 0; i < lim && exp_q.size() > 0; i++) @(negedge clk);
    chk("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; irq = 1'b0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 pc", 64'(dbg_pc), 0);
    chk("R1 acc", 64'(dbg_acc), 0);
    chk("R1 ack/handler/rd/wr", {60'd0, irq_ack, in_handler, mem_rd, mem_wr}, 0);
    do_reset();

    // ---------- program 1: arithmetic, store, jumps ----------
    poke(0, {ins(OP_LOAD, 100), ins(OP_ADD, 101)});
    poke(1, {ins(OP_STORE, 200), ins(OP_SUB, 102)});
    poke(2, {ins(OP_STORE, 201), ins(OP_JGE, 9)});
    poke(3, {ins(OP_STORE, 202), ins(OP_ADD, 102)});
    poke(4, {ins(OP_JGE, 6), ins(OP_STORE, 203)});
    poke(5, {ins(OP_STORE, 205), ins(8'h00, 0)});
    poke(6, {ins(OP_LOAD, 104), ins(OP_STORE, 204)});
    poke(7, {ins(OP_JUMP, 7), ins(8'h77, 0)});
    poke(100, 40'd10); poke(101, 40'd25); poke(102, 40'd40); poke(104, 40'd7);
    expect_wr(200, 40'd35);
    expect_wr(201, 40'hFF_FFFF_FFFB);   // R5 SUB wraps modulo 2^40
    expect_wr(202, 40'hFF_FFFF_FFFB);   // R6 JGE not taken on negative
    expect_wr(204, 40'd7);
    strict = 1'b1;
    @(negedge clk); run = 1'b1;
    drain(2000);
    repeat (80) @(negedge clk);
    chk("R9 first write cycle", 64'(first_wr), 64'd16);
    chk("R2 reads before first write", 64'(rd_before_wr), 64'd4);
    chk("R6 total writes (discarded right slot)", 64'(n_wr), 64'd4);
    chk("R6 spin pc", 64'(dbg_pc), 64'd7);
    chk("R5 acc after LOAD", 64'(dbg_acc), 64'd7);
    // R10 freeze
    begin
      logic [AW-1:0] p; logic [WW-1:0] a;
      run = 1'b0; p = dbg_pc; a = dbg_acc;
      repeat (10) @(negedge clk);
      chk("R10 pc frozen", 64'(dbg_pc), 64'(p));
      chk("R10 acc frozen", 64'(dbg_acc), 64'(a));
    end

    // ---------- program 2: interrupt entry, mask, return ----------
    do_reset();
    chk("R1 pc after second reset", 64'(dbg_pc), 0);
    poke(0, {ins(OP_LOAD, 200), ins(OP_ADD, 101)});
    poke(1, {ins(OP_STORE, 200), ins(OP_JUMP, 0)});
    poke(768, {ins(OP_STORE, 300), ins(OP_LOAD, 102)});
    poke(769, {ins(OP_STORE, 301), ins(OP_RETI, 0)});
    poke(200, 40'd5); poke(101, 40'd1); poke(102, 40'd99);
    expect_wr(300, 40'd5);
    expect_wr(301, 40'd99);
    expect_wr(200, 40'd6);   // R8 buffered ADD resumes with restored acc
    expect_wr(200, 40'd7);
    expect_wr(200, 40'd8);
    irq = 1'b1;
    @(negedge clk); run = 1'b1;
    for (int i = 0; i < 500 && first_ack < 0; i++) @(negedge clk);
    chk("R7 ack cycle", 64'(first_ack), 64'd6);
    chk("R7 pc at handler", 64'(dbg_pc), 64'd768);
    chk("R7 in_handler set", 64'(in_handler), 64'd1);
    for (int i = 0; i < 500 && !seen301; i++) @(negedge clk);
    chk("R8 no ack while masked", 64'(n_ack), 64'd1);
    irq = 1'b0;
    drain(2000);
    run = 1'b0;
    chk("R8 in_handler cleared", 64'(in_handler), 64'd0);
    chk("R8 single ack overall", 64'(n_ack), 64'd1);

    // ---------- program 3: pc wrap ----------
    do_reset();
    poke(0, {ins(OP_JUMP, 999), ins(8'h00, 0)});
    poke(999, {ins(OP_LOAD, 104), ins(8'h00, 0)});
    poke(104, 40'd7);
    @(negedge clk); run = 1'b1;
    for (int i = 0; i < 200 && dbg_pc != 12'd999; i++) @(negedge clk);
    chk("R6 jump to last word", 64'(dbg_pc), 64'd999);
    for (int i = 0; i < 200 && dbg_pc != 12'd0; i++) @(negedge clk);
    chk("R3 pc wrapped", 64'(dbg_pc), 64'd0);
    chk("R3 acc loaded before wrap", 64'(dbg_acc), 64'd7);
    run = 1'b0;
    done = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule